// File: doc/BRIEF.md
# Merged-Region Trie Child Address Calculator

This block resolves, for one level of a multi-bit trie, which child node a lookup key leads to and where that child sits in memory. The level splits its address space into equal-size regions selected by a slice of the key. Sparse sibling regions may have been folded together into merged regions, so the child position is not simply the slice value. The node header carries two short ascending lists of region boundaries. One describes the merged area grown upward from the lowest indices, and the other describes the merged area grown downward from the highest indices. The block turns the slice and the two lists into a dense child index and adds it to the child base address.

One lookup is accepted per cycle. The address appears on the output one cycle after the request, together with its own valid flag. Node fetch and decoding of the rest of the header belong to the surrounding pipeline.

Top module: `trie_child_addr`

## Requirements
- R1: The slice is the low `cut` bits of the 10-bit key with the upper bits forced to zero. A cut of 0 gives slice 0, and any cut above 10 uses all 10 bits.
- R2: Low branch. When slice <= low[Lc-1], the index is the largest position i < Lc with low[i] <= slice. The index is 0 when no such position exists.
- R3: High branch. When slice > low[Lc-1] and slice >= high[0], the index is j + high[0] - low[Lc-1] + Lc - 1. Here j is the largest position j < Hc with high[j] <= slice.
- R4: Middle branch. When slice > low[Lc-1] and slice < high[0], the index is slice - low[Lc-1] + Lc - 1.
- R5: When the conditions of the low and high branches both hold, the low branch is used.
- R6: The output address is base + index, taken modulo 2^16.
- R7: The counts Lc and Hc are the input counts clamped to the range 1..5, so a count of 0 acts as 1 and a count of 6 or 7 acts as 5. List entries at or beyond the effective count have no effect on the result.
- R8: out_valid equals in_valid of the previous cycle, and out_addr carries the result for the request made in that cycle.
- R9: While in_valid is low, out_addr keeps its value whatever the other inputs do.
- R10: After a synchronous active-low reset, out_valid is 0 and out_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A request is present this cycle |
| key_bits | input | 10 | Key bits that follow this node's position |
| cut | input | 4 | Number of key bits this node consumes |
| base_addr | input | 16 | Address of the node's first child |
| low_idx | input | 5x10 | Ascending boundaries of the upward merged area, entry 0 in the low bits |
| low_cnt | input | 3 | Number of valid low entries |
| high_idx | input | 5x10 | Ascending boundaries of the downward merged area, entry 0 in the low bits |
| high_cnt | input | 3 | Number of valid high entries |
| out_valid | output | 1 | out_addr holds a new result |
| out_addr | output | 16 | Child node address |

## Verification
The low-branch test and the high-branch test can both succeed for the same request. This happens when the first high boundary lies at or below the last low boundary and the slice sits between them. Directed requests build such overlapping lists. The result is judged against the low-branch index, and a result that follows the high-branch formula is treated as a failure. Random requests with well-formed lists cover the three branches separately. Cut values above 10 and counts outside 1..5 are also exercised.

// File: rtl/trie_child_pkg.sv
// Shared types for the trie child address calculator.
package trie_child_pkg;
    // Which branch of the index computation applies to a request.
    typedef enum logic [1:0] {
        REG_LOW  = 2'd0,
        REG_HIGH = 2'd1,
        REG_MID  = 2'd2
    } region_e;
endpackage

// File: rtl/trie_child_slice.sv
// Extracts the slice of key bits this node consumes.
// Assumes: a cut above IDX_W means the whole key is used.
module trie_child_slice #(
    parameter int IDX_W = 10,
    parameter int CUT_W = 4
) (
    input  logic [IDX_W-1:0] key_bits,
    input  logic [CUT_W-1:0] cut,
    output logic [IDX_W-1:0] slice
);
    logic [CUT_W-1:0] eff_cut;
    logic [IDX_W:0]   mask;

    // Clamp the cut, build a low-bit mask from it and apply the mask.
    always_comb begin
        eff_cut = (cut > CUT_W'(IDX_W)) ? CUT_W'(IDX_W) : cut;
        mask    = ((IDX_W+1)'(1) << eff_cut) - (IDX_W+1)'(1);
        slice   = key_bits & mask[IDX_W-1:0];
    end
endmodule

// File: rtl/trie_child_scan.sv
// Finds the highest valid position whose boundary does not exceed the key.
// Assumes: cnt is already clamped to 1..N; returns 0 when nothing qualifies.
module trie_child_scan #(
    parameter int N     = 5,
    parameter int IDX_W = 10,
    parameter int CNT_W = 3
) (
    input  logic [N-1:0][IDX_W-1:0] ent,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [IDX_W-1:0]        key,
    output logic [CNT_W-1:0]        pos
);
    logic [N-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hit[g] = (CNT_W'(g) < cnt) && (ent[g] <= key);
        end
    endgenerate

    // Priority pick: the last qualifying entry wins.
    always_comb begin
        pos = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) pos = CNT_W'(i);
        end
    end
endmodule

// File: rtl/trie_child_addr.sv
// Top: computes the next trie node address for one level with merged regions.
// Assumes: boundary lists ascend; the result is registered one cycle later.
module trie_child_addr #(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 10,
    parameter int CUT_W   = 4,
    parameter int NUM_ENT = 5,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [IDX_W-1:0]              key_bits,
    input  logic [CUT_W-1:0]              cut,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [NUM_ENT-1:0][IDX_W-1:0] low_idx,
    input  logic [CNT_W-1:0]              low_cnt,
    input  logic [NUM_ENT-1:0][IDX_W-1:0] high_idx,
    input  logic [CNT_W-1:0]              high_cnt,
    output logic                          out_valid,
    output logic [ADDR_W-1:0]             out_addr
);
    import trie_child_pkg::*;

    logic [IDX_W-1:0]  slice;
    logic [CNT_W-1:0]  lc, hc, lpos, hpos;
    logic [IDX_W-1:0]  low_last;
    region_e           region;
    logic [ADDR_W-1:0] index;

    // Clamp both header counts into 1..NUM_ENT.
    always_comb begin
        lc = (low_cnt == '0) ? CNT_W'(1) :
             (low_cnt > CNT_W'(NUM_ENT)) ? CNT_W'(NUM_ENT) : low_cnt;
        hc = (high_cnt == '0) ? CNT_W'(1) :
             (high_cnt > CNT_W'(NUM_ENT)) ? CNT_W'(NUM_ENT) : high_cnt;
    end

    trie_child_slice #(.IDX_W(IDX_W), .CUT_W(CUT_W)) u_slice (
        .key_bits (key_bits),
        .cut      (cut),
        .slice    (slice)
    );

    trie_child_scan #(.N(NUM_ENT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_low_scan (
        .ent (low_idx),
        .cnt (lc),
        .key (slice),
        .pos (lpos)
    );

    trie_child_scan #(.N(NUM_ENT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_high_scan (
        .ent (high_idx),
        .cnt (hc),
        .key (slice),
        .pos (hpos)
    );

    // Classify the slice; the low branch takes precedence.
    always_comb begin
        low_last = low_idx[lc - CNT_W'(1)];
        if (slice <= low_last)        region = REG_LOW;
        else if (slice >= high_idx[0]) region = REG_HIGH;
        else                           region = REG_MID;
    end

    // Form the dense child index for the chosen branch.
    always_comb begin
        unique case (region)
            REG_LOW:  index = ADDR_W'(lpos);
            REG_HIGH: index = ADDR_W'(hpos) + ADDR_W'(high_idx[0]) - ADDR_W'(low_last)
                              + ADDR_W'(lc) - ADDR_W'(1);
            default:  index = ADDR_W'(slice) - ADDR_W'(low_last)
                              + ADDR_W'(lc) - ADDR_W'(1);
        endcase
    end

    // Output register: capture the address on a request, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_addr <= base_addr + index;
        end
    end
endmodule

// File: rtl/trie_child_addr_chk.sv
// Checker for trie_child_addr: handshake timing, hold and a cut-zero case.
// Assumes: attached to every instance through the bind below.
module trie_child_addr_chk #(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 10,
    parameter int CUT_W   = 4,
    parameter int NUM_ENT = 5,
    parameter int CNT_W   = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [CUT_W-1:0]              cut,
    input logic [ADDR_W-1:0]             base_addr,
    input logic [NUM_ENT-1:0][IDX_W-1:0] low_idx,
    input logic [CNT_W-1:0]              low_cnt,
    input logic                          out_valid,
    input logic [ADDR_W-1:0]             out_addr
);
    // R8: the valid flag follows the request by one cycle.
    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R9: without a request the address does not move.
    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

    // R10: the cycle after reset shows no valid output.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_addr == '0));

    // R1: a zero cut with one zero low boundary selects the base itself.
    assert_cut_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cut == '0 && low_cnt == CNT_W'(1) && low_idx[0] == '0)
        |=> (out_addr == $past(base_addr)));
endmodule

bind trie_child_addr trie_child_addr_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CUT_W(CUT_W), .NUM_ENT(NUM_ENT), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cut       (cut),
    .base_addr (base_addr),
    .low_idx   (low_idx),
    .low_cnt   (low_cnt),
    .out_valid (out_valid),
    .out_addr  (out_addr)
);

// File: tb/trie_child_addr_tb.sv
// Self-checking bench: directed corner cases plus seeded random requests.
module trie_child_addr_tb;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [9:0]       key_bits = '0;
    logic [3:0]       cut = '0;
    logic [15:0]      base_addr = '0;
    logic [4:0][9:0]  low_idx = '0;
    logic [2:0]       low_cnt = 3'd1;
    logic [4:0][9:0]  high_idx = '0;
    logic [2:0]       high_cnt = 3'd1;
    logic             out_valid;
    logic [15:0]      out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    trie_child_addr u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .key_bits(key_bits),
        .cut(cut), .base_addr(base_addr), .low_idx(low_idx), .low_cnt(low_cnt),
        .high_idx(high_idx), .high_cnt(high_cnt), .out_valid(out_valid),
        .out_addr(out_addr)
    );

    // Reference model written straight from the requirements.
    function automatic logic [15:0] ref_addr(output string tag);
        int s, n, lcn, hcn, last, idx, j;
        n   = (cut > 10) ? 10 : int'(cut);
        s   = int'(key_bits) % (1 << n);
        lcn = (low_cnt == 0) ? 1 : (low_cnt > 5) ? 5 : int'(low_cnt);
        hcn = (high_cnt == 0) ? 1 : (high_cnt > 5) ? 5 : int'(high_cnt);
        last = int'(low_idx[lcn-1]);
        if (s <= last) begin
            tag = "R2";
            idx = 0;
            for (int i = 0; i < lcn; i++) if (int'(low_idx[i]) <= s) idx = i;
        end else if (s >= int'(high_idx[0])) begin
            tag = "R3";
            j = 0;
            for (int i = 0; i < hcn; i++) if (int'(high_idx[i]) <= s) j = i;
            idx = j + int'(high_idx[0]) - last + lcn - 1;
        end else begin
            tag = "R4";
            idx = s - last + lcn - 1;
        end
        return 16'(int'(base_addr) + idx);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One request, checked on the following cycle, then a hold probe.
    task automatic run_req(input string req);
        logic [15:0] exp;
        string tag;
        exp = ref_addr(tag);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, "/R8 valid"}, 16'(out_valid), 16'd1);
        check({req, "/", tag, "/R6"}, out_addr, exp);
        base_addr = base_addr ^ 16'h5a5a;
        key_bits  = ~key_bits;
        @(negedge clk);
        check("R9 hold", out_addr, exp);
        check("R8 no valid", 16'(out_valid), 16'd0);
    endtask

    task automatic set_lists(input int l0, l1, l2, l3, l4, input int lc,
                             input int h0, h1, h2, h3, h4, input int hc);
        low_idx  = {10'(l4), 10'(l3), 10'(l2), 10'(l1), 10'(l0)};
        high_idx = {10'(h4), 10'(h3), 10'(h2), 10'(h1), 10'(h0)};
        low_cnt  = 3'(lc);
        high_cnt = 3'(hc);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset valid", 16'(out_valid), 16'd0);
        check("R10 reset addr", out_addr, 16'd0);

        // Worked case: high branch gives index 9.
        set_lists(0, 1, 3, 0, 0, 3, 9, 10, 0, 0, 0, 2);
        cut = 4'd10; key_bits = 10'd10; base_addr = 16'h0100;
        run_req("R3 worked");
        // Middle region between the two merged areas.
        set_lists(0, 1, 3, 0, 0, 3, 9, 10, 0, 0, 0, 2);
        key_bits = 10'd6; base_addr = 16'h0100; run_req("R4 mid");
        // Low branch, exact boundary hit.
        key_bits = 10'd3; base_addr = 16'h0200; run_req("R2 edge");
        // Slice below the first low boundary gives index 0.
        set_lists(2, 4, 0, 0, 0, 2, 9, 0, 0, 0, 0, 1);
        key_bits = 10'd1; base_addr = 16'h0300; run_req("R2 none");
        // Overlapping conditions: low branch must win.
        set_lists(0, 2, 8, 0, 0, 3, 5, 7, 0, 0, 0, 2);
        key_bits = 10'd7; base_addr = 16'h0400; run_req("R5 overlap");
        // Cut zero, and cut above the key width.
        set_lists(0, 0, 0, 0, 0, 1, 500, 0, 0, 0, 0, 1);
        cut = 4'd0; key_bits = 10'h3ff; base_addr = 16'h0500; run_req("R1 cut0");
        cut = 4'd15; key_bits = 10'h3ff; base_addr = 16'h0500; run_req("R1 cut15");
        cut = 4'd3; key_bits = 10'h3fd; base_addr = 16'h0500; run_req("R1 cut3");
        // Count clamps and ignored entries.
        set_lists(0, 900, 901, 902, 903, 0, 950, 0, 0, 0, 0, 0);
        cut = 4'd10; key_bits = 10'd600; base_addr = 16'h0600; run_req("R7 cnt0");
        set_lists(0, 1, 2, 3, 4, 7, 20, 30, 40, 50, 60, 6);
        key_bits = 10'd55; base_addr = 16'h0700; run_req("R7 cnt7");
        // Address wrap.
        set_lists(0, 1, 2, 0, 0, 3, 20, 0, 0, 0, 0, 1);
        key_bits = 10'd25; base_addr = 16'hfffe; run_req("R6 wrap");

        // Random requests with ascending lists.
        for (int n = 0; n < 400; n++) begin
            int v;
            v = 0;
            for (int i = 0; i < 5; i++) begin
                low_idx[i] = 10'(v);
                v += 1 + int'($urandom_range(0, 3));
            end
            v = int'($urandom_range(20, 600));
            for (int i = 0; i < 5; i++) begin
                high_idx[i] = 10'(v);
                v += 1 + int'($urandom_range(0, 80));
            end
            low_cnt   = 3'($urandom_range(0, 7));
            high_cnt  = 3'($urandom_range(0, 7));
            cut       = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'd10;
            key_bits  = 10'($urandom);
            base_addr = 16'($urandom);
            run_req("rand");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule